// File: doc/BRIEF.md
# Inline Jump Table Dispatch Unit

This unit carries out a bounded switch-case dispatch. Software places a table of 24-bit target addresses straight after the opcode in the instruction stream. The unit receives the address of the first table slot, an 8-bit selector and an 8-bit limit. The limit counts table entries minus one, so a limit of `lim` means the table holds `lim+1` slots.

When the selector is within the table, the unit reads the chosen slot one byte at a time through a byte-wide memory port. It then reports a subroutine call: the new instruction pointer is the fetched target, and a push request carries the address of the first byte after the table. When the selector lies beyond the table, no memory is read and no call is made. Instead the unit raises the overflow and error flags, and execution resumes just past the table.

The flag word enters at start. It comes back with only the overflow and error bits rewritten, so flags set by the instruction that computed the selector survive the dispatch.

Top module: `jtbl_dispatch`

## Requirements
- R1: During and after reset, `done_o`, `push_o`, `mem_rd_o` and `busy_o` are 0, and `ip_o` is 0.
- R2: For an in-range selector, the slot address is `(ip_i + 3*sel_i) mod 2^24`. Three reads are issued on consecutive cycles at the slot address, slot+1 and slot+2, each wrapping at 24 bits. Read data returns one cycle after its request. The target is assembled little-endian: the byte at the slot address is bits 7:0 and the byte at slot+2 is bits 23:16.
- R3: A selector is in range when `sel_i <= lim_i`, so `sel_i == lim_i` is in range. In that case, with `done_o` high, `ip_o` equals the fetched target, `push_o` is 1 and `push_addr_o` equals the return point.
- R4: When `sel_i > lim_i`, no memory read is issued. `push_o` stays 0 and `ip_o` equals the return point when `done_o` is high.
- R5: The return point is `(ip_i + 3*lim_i + 3) mod 2^24`, wrapping past the top of the address space.
- R6: With `done_o` high, the overflow bit (bit 6 of `flags_o`) and the error bit (bit 1) are both 1 for an out-of-range selector and both 0 for an in-range one. Every other bit of `flags_o` equals the same bit of `flags_i` as sampled at start.
- R7: `done_o` is a single-cycle pulse. With the start edge counted as edge 0, `done_o` is high after edge 1 for an out-of-range dispatch and after edge 4 for an in-range one.
- R8: `start_i` is ignored while `busy_o` is high. Such a pulse produces no extra result and does not change the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a dispatch (sampled when idle) |
| ip_i | input | 24 | Address of the first table slot |
| sel_i | input | 8 | Selector |
| lim_i | input | 8 | Last valid selector value |
| flags_i | input | 8 | Flag word before the dispatch |
| mem_rd_o | output | 1 | Byte read request |
| mem_addr_o | output | 24 | Byte read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the request |
| busy_o | output | 1 | A dispatch is in progress |
| done_o | output | 1 | Result valid, one-cycle pulse |
| ip_o | output | 24 | New instruction pointer |
| push_o | output | 1 | Push request for the return address |
| push_addr_o | output | 24 | Return address to push |
| flags_o | output | 8 | Flag word after the dispatch |

## Verification
The assertions assume the memory returns each byte exactly one cycle after its request. They also assume `start_i` matters only while the unit is idle, so the operands need to be valid only on the start edge. The stimulus meets both assumptions: it uses a registered memory model whose contents are a fixed function of the address, and it drives single-cycle start pulses at the falling edge. A pulse given deliberately mid-dispatch checks that a busy unit ignores it. Corner cases include the selector equal to the limit, a table spanning the top of the address space, and a return point that wraps.

// File: rtl/jtbl_pkg.sv
// Shared definitions for the jump table dispatch unit.
// Assumes a 24-bit byte address space and three-byte table entries.
package jtbl_pkg;
    localparam int ADDR_W    = 24;
    localparam int ENTRY_B   = 3;
    localparam int SEL_W     = 8;
    localparam int FLAG_W    = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SKIP  = 2'd2
    } disp_state_e;
endpackage

// File: rtl/jtbl_addr_calc.sv
// Address arithmetic for the dispatch: slot address, return point and range test.
// Purely combinational; all sums wrap at the address width.
module jtbl_addr_calc #(
    parameter int AW      = 24,
    parameter int SW      = 8,
    parameter int ENTRY_B = 3
) (
    input  logic [AW-1:0] base_i,
    input  logic [SW-1:0] sel_i,
    input  logic [SW-1:0] lim_i,
    output logic [AW-1:0] slot_o,
    output logic [AW-1:0] ret_o,
    output logic          in_range_o
);
    localparam logic [AW-1:0] STRIDE = AW'(ENTRY_B);

    // Scale the selector and limit by the entry size and add to the base.
    always_comb begin
        slot_o     = base_i + AW'(sel_i) * STRIDE;
        ret_o      = base_i + AW'(lim_i) * STRIDE + STRIDE;
        in_range_o = (sel_i <= lim_i);
    end
endmodule

// File: rtl/jtbl_fetch.sv
// Fetches one little-endian table entry through a byte read port.
// Assumes read data arrives one cycle after each request. Issues NBYTES reads
// back to back and presents the whole word combinationally with word_vld_o.
module jtbl_fetch #(
    parameter int AW     = 24,
    parameter int NBYTES = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [AW-1:0]      base_i,
    output logic               mem_rd_o,
    output logic [AW-1:0]      mem_addr_o,
    input  logic [7:0]         mem_rdata_i,
    output logic               word_vld_o,
    output logic [8*NBYTES-1:0] word_o
);
    localparam int CW = $clog2(NBYTES + 1);
    localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);
    localparam logic [CW-1:0] ALL  = CW'(NBYTES);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] n_iss_q;
    logic          act_q;
    logic          rd_q;
    logic [CW-1:0] rd_idx_q;
    logic [7:0]    bytes_q [NBYTES];

    assign mem_rd_o   = act_q && (n_iss_q != ALL);
    assign mem_addr_o = addr_q + AW'(n_iss_q);
    assign word_vld_o = rd_q && (rd_idx_q == LAST);

    // Assemble the word: earlier bytes from storage, the last one straight from the port.
    generate
        for (genvar b = 0; b < NBYTES; b++) begin : g_word
            if (b == NBYTES - 1) begin : g_last
                assign word_o[8*b +: 8] = mem_rdata_i;
            end else begin : g_held
                assign word_o[8*b +: 8] = bytes_q[b];
            end
        end
    endgenerate

    // Request sequencer: count issued reads and track which byte returns next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            n_iss_q  <= '0;
            act_q    <= 1'b0;
            rd_q     <= 1'b0;
            rd_idx_q <= '0;
        end else if (go_i && !act_q) begin
            addr_q   <= base_i;
            n_iss_q  <= '0;
            act_q    <= 1'b1;
            rd_q     <= 1'b0;
        end else if (act_q) begin
            rd_q <= mem_rd_o;
            if (mem_rd_o) begin
                rd_idx_q <= n_iss_q;
                n_iss_q  <= n_iss_q + 1'b1;
            end
            if (word_vld_o) begin
                act_q <= 1'b0;
                rd_q  <= 1'b0;
            end
        end
    end

    // Capture each returning byte into its lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) bytes_q[i] <= '0;
        end else if (rd_q) begin
            bytes_q[rd_idx_q] <= mem_rdata_i;
        end
    end

    // R2: back-to-back reads walk upward one byte at a time.
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

    // R2: a byte is captured only in the cycle after a request.
    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |-> $past(mem_rd_o));
endmodule

// File: rtl/jtbl_dispatch.sv
// Switch-case dispatch unit. Given the first table slot address, a selector and
// a limit, it either fetches a 24-bit target and requests a call, or skips the
// table and flags the miss in V and ER. No other flag bit is modified.
// Assumes start_i is honoured only when idle and that memory has one-cycle read latency.
module jtbl_dispatch #(
    parameter int AW     = jtbl_pkg::ADDR_W,
    parameter int SW     = jtbl_pkg::SEL_W,
    parameter int FW     = jtbl_pkg::FLAG_W,
    parameter int V_BIT  = 6,
    parameter int ER_BIT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] ip_i,
    input  logic [SW-1:0] sel_i,
    input  logic [SW-1:0] lim_i,
    input  logic [FW-1:0] flags_i,
    output logic          mem_rd_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic [7:0]    mem_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [AW-1:0] ip_o,
    output logic          push_o,
    output logic [AW-1:0] push_addr_o,
    output logic [FW-1:0] flags_o
);
    import jtbl_pkg::*;

    localparam int            TW      = 8 * ENTRY_B;
    localparam logic [FW-1:0] VE_MASK = (FW'(1) << V_BIT) | (FW'(1) << ER_BIT);

    disp_state_e   state_q;
    logic [AW-1:0] slot_w, ret_w, ret_q;
    logic          in_range_w;
    logic [FW-1:0] flags_q;
    logic [SW-1:0] sel_q;
    logic          go_w;
    logic          word_vld_w;
    logic [TW-1:0] word_w;

    assign busy_o = (state_q != ST_IDLE);
    assign go_w   = (state_q == ST_IDLE) && start_i && in_range_w;

    jtbl_addr_calc #(.AW(AW), .SW(SW), .ENTRY_B(ENTRY_B)) u_calc (
        .base_i     (ip_i),
        .sel_i      (sel_i),
        .lim_i      (lim_i),
        .slot_o     (slot_w),
        .ret_o      (ret_w),
        .in_range_o (in_range_w)
    );

    jtbl_fetch #(.AW(AW), .NBYTES(ENTRY_B)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go_w),
        .base_i      (slot_w),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .mem_rdata_i (mem_rdata_i),
        .word_vld_o  (word_vld_w),
        .word_o      (word_w)
    );

    // Control: accept a start when idle, then finish via fetch or skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= '0;
            flags_q <= '0;
            sel_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    ret_q   <= ret_w;
                    flags_q <= flags_i;
                    sel_q   <= sel_i;
                    state_q <= in_range_w ? ST_FETCH : ST_SKIP;
                end
                ST_FETCH: if (word_vld_w) state_q <= ST_IDLE;
                ST_SKIP:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Result registers: publish the new IP, push request and flags for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            push_o      <= 1'b0;
            ip_o        <= '0;
            push_addr_o <= '0;
            flags_o     <= '0;
        end else begin
            done_o <= 1'b0;
            push_o <= 1'b0;
            if (state_q == ST_FETCH && word_vld_w) begin
                done_o      <= 1'b1;
                push_o      <= 1'b1;
                ip_o        <= AW'(word_w);
                push_addr_o <= ret_q;
                flags_o     <= flags_q & ~VE_MASK;
            end else if (state_q == ST_SKIP) begin
                done_o  <= 1'b1;
                ip_o    <= ret_q;
                flags_o <= flags_q | VE_MASK;
            end
        end
    end

    // R7: the completion strobe lasts a single cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: the skip path never touches memory.
    a_r4_no_read_on_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !mem_rd_o);

    // R6: V and ER agree and are the inverse of the call decision.
    a_r6_ve_tracks_call: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flags_o[V_BIT] == flags_o[ER_BIT]) && (flags_o[V_BIT] == !push_o));

    // R3: a push request only accompanies a completed dispatch.
    a_r3_push_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> done_o);

    // R8: operands captured at start hold while busy.
    a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(sel_q) && $stable(ret_q)));
endmodule

// File: tb/jtbl_dispatch_tb.sv
// Scoreboard bench: the driver queues expected results, the monitor checks them on done.
module jtbl_dispatch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] ip_i = '0;
    logic [7:0]  sel_i = '0, lim_i = '0, flags_i = '0;
    logic        mem_rd_o;
    logic [23:0] mem_addr_o;
    logic [7:0]  mem_rdata_i = '0;
    logic        busy_o, done_o, push_o;
    logic [23:0] ip_o, push_addr_o;
    logic [7:0]  flags_o;

    always #2.5 clk = ~clk;

    jtbl_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ip_i(ip_i), .sel_i(sel_i),
        .lim_i(lim_i), .flags_i(flags_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o), .ip_o(ip_o),
        .push_o(push_o), .push_addr_o(push_addr_o), .flags_o(flags_o)
    );

    typedef struct {
        logic [23:0] ip;
        logic        push;
        logic [23:0] ra;
        logic [7:0]  fl;
        int          lat;
        int          rds;
        int          t0;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0, cyc = 0, rd_cnt = 0, done_cnt = 0;
    bit finished = 0;

    function automatic logic [7:0] mb(input logic [23:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ (a[23:16] + 8'h35);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // Registered memory model: one-cycle read latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_o) mem_rdata_i <= mb(mem_addr_o);
    end

    // Monitor: count reads, pop and compare on each done.
    always @(negedge clk) begin
        if (rst_n && mem_rd_o) rd_cnt++;
        if (rst_n && done_o) begin
            done_cnt++;
            if (q.size() == 0) begin
                chk(0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(push_o == e.push, "R3/R4 push", push_o, e.push);
                chk(ip_o == e.ip, "R2/R3/R4 ip", ip_o, e.ip);
                if (e.push) chk(push_addr_o == e.ra, "R5 return addr", push_addr_o, e.ra);
                chk(flags_o == e.fl, "R6 flags", flags_o, e.fl);
                chk((cyc - e.t0) == e.lat, "R7 latency", cyc - e.t0, e.lat);
                chk(rd_cnt == e.rds, "R2/R4 read count", rd_cnt, e.rds);
            end
            rd_cnt = 0;
        end
    end

    task automatic run_case(input logic [23:0] ip, input logic [7:0] sel,
                            input logic [7:0] lim, input logic [7:0] fl, input bit extra);
        exp_t e;
        logic [23:0] slot, ret;
        slot = ip + 24'(sel) * 24'd3;
        ret  = ip + 24'(lim) * 24'd3 + 24'd3;
        e.ra = ret;
        if (sel <= lim) begin
            e.push = 1'b1;
            e.ip   = {mb(slot + 24'd2), mb(slot + 24'd1), mb(slot)};
            e.fl   = fl & ~8'h42;
            e.lat  = 5;
            e.rds  = 3;
        end else begin
            e.push = 1'b0;
            e.ip   = ret;
            e.fl   = fl | 8'h42;
            e.lat  = 2;
            e.rds  = 0;
        end
        @(negedge clk);
        ip_i = ip; sel_i = sel; lim_i = lim; flags_i = fl; start_i = 1'b1;
        e.t0 = cyc;
        q.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        if (extra) begin
            // R8: a start while busy with out-of-range operands must be ignored.
            ip_i = 24'h0ABCDE; sel_i = 8'd9; lim_i = 8'd1; flags_i = 8'h00; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base_done;
        repeat (4) @(negedge clk);
        // R1: reset state.
        chk(!done_o && !push_o && !mem_rd_o && !busy_o, "R1 strobes low in reset",
            {done_o, push_o, mem_rd_o, busy_o}, 0);
        chk(ip_o == 24'h0, "R1 ip zero", ip_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o, "R1 idle after reset", {busy_o, done_o}, 0);

        run_case(24'h001000, 8'd0,   8'd0,   8'h00, 0); // R3 single entry, sel == lim
        run_case(24'h123456, 8'd5,   8'd10,  8'hFF, 0); // R6 other bits kept while V/ER cleared
        run_case(24'h200000, 8'd10,  8'd10,  8'h81, 0); // R3 boundary sel == lim
        run_case(24'h300000, 8'd11,  8'd10,  8'h25, 0); // R4 just out of range
        run_case(24'hFFFF00, 8'd255, 8'd255, 8'h3C, 0); // R5 slot and return wrap
        run_case(24'hFFFFFE, 8'd0,   8'd4,   8'h10, 0); // R2 bytes straddle the top
        run_case(24'hFFFFF0, 8'd200, 8'd7,   8'h42, 0); // R5 wrapped return on skip
        for (int k = 0; k < 6; k++)
            run_case(24'h040000 + 24'(k) * 24'h1111, 8'(k * 13), 8'(40 - k * 3), 8'(k * 37), 0);
        base_done = done_cnt;
        run_case(24'h055500, 8'd3, 8'd4, 8'h08, 1);        // R8 start while busy
        repeat (8) @(negedge clk);
        chk(done_cnt == base_done + 1, "R8 single result", done_cnt - base_done, 1);
        chk(!busy_o, "R8 idle afterwards", busy_o, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule